// File: doc/BRIEF.md
# Decode-Stage Hazard Stall Unit

This block sits in the decode stage of a five-stage in-order pipeline that compares branch operands and computes branch targets in decode. Every cycle it looks at the source registers of the instruction in decode and at the destination and write/read flags of the instructions in execute and memory. From these it decides whether the decode instruction needs a value that the forwarding network cannot yet deliver.

When a value is missing, the unit freezes the program counter and the fetch/decode register and zeroes the control fields entering execute. This inserts one bubble per stall cycle. When a branch resolves as taken in decode, the unit instead asks for the fetch/decode register to be flushed, which discards the one instruction that was fetched behind the branch.

The decision is combinational, so it takes effect in the same cycle. A three-state hold sequencer records how many consecutive cycles the pipeline has been frozen. It has these states:
- `ST_RUN`: no stall in the previous cycle.
- `ST_HOLD_ONE`: one stall cycle so far.
- `ST_HOLD_TWO`: two stall cycles so far.

Its transitions are:
- advance from RUN to HOLD_ONE to HOLD_TWO on each stalled cycle;
- return to RUN on any cycle without a stall.

While reset is asserted, the sequencer forces the outputs to the free-running values.

Top module: `hazard_stall_unit`

## Requirements
- R1: When the execute-stage instruction reads memory and its destination matches a used source register of the decode instruction, the unit stalls in that same cycle: pc_write=0, ifid_write=0, control_zero=1.
- R2: An ALU (non-branch) consumer of a load result that immediately precedes it is held for exactly one cycle.
- R3: A decode-stage branch whose compared register is written by the immediately preceding ALU instruction is held for exactly one cycle.
- R4: A decode-stage branch whose compared register is written by a load two instructions earlier is held for exactly one cycle.
- R5: A decode-stage branch whose compared register is written by the immediately preceding load is held for exactly two cycles, and never more than two consecutive stall cycles occur.
- R6: No stall occurs when an ALU producer feeds an ALU consumer at any distance, or feeds a branch two or three instructions later.
- R7: A producer whose destination is register 0 never causes a stall.
- R8: A source register whose use flag (id_uses_rs / id_uses_rt) is 0 never causes a stall.
- R9: A branch in decode with id_branch_taken=1 and no stall raises ifid_flush=1 in that cycle. A not-taken branch raises no flush.
- R10: A stall has priority over a flush: ifid_flush=0 in any cycle with control_zero=1.
- R11: While rst_n=0, the outputs are pc_write=1, ifid_write=1, control_zero=0, ifid_flush=0, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| id_rs | input | REG_W | First source register of the decode instruction |
| id_rt | input | REG_W | Second source register of the decode instruction |
| id_uses_rs | input | 1 | Decode instruction reads id_rs |
| id_uses_rt | input | 1 | Decode instruction reads id_rt |
| id_is_branch | input | 1 | Decode instruction is a branch compared in decode |
| id_branch_taken | input | 1 | Branch comparison in decode resolves as taken |
| ex_rd | input | REG_W | Destination register of the execute instruction |
| ex_reg_write | input | 1 | Execute instruction writes a register |
| ex_mem_read | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_W | Destination register of the memory-stage instruction |
| mem_reg_write | input | 1 | Memory-stage instruction writes a register |
| mem_mem_read | input | 1 | Memory-stage instruction is a load |
| pc_write | output | 1 | Allow the PC to update |
| ifid_write | output | 1 | Allow the fetch/decode register to update |
| control_zero | output | 1 | Zero the control fields written into decode/execute |
| ifid_flush | output | 1 | Clear the fetch/decode register (taken branch) |

## Verification
The hold sequencer's state has no effect on the outputs. A wrong stall decision, however, shows at the ports within the same cycle, as a missing or extra cycle with pc_write low. It then carries into the next cycle, because the bubble it inserts changes what sits in execute and memory. The bench therefore runs instruction sequences through a stage-occupancy model driven by the unit's own stall and flush outputs. It counts the stall and flush cycles for each sequence, so an off-by-one in the stall length for a given producer distance shows up as a wrong count for that sequence.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_HOLD_ONE = 2'd1,
        ST_HOLD_TWO = 2'd2
    } hold_state_e;

endpackage

// File: rtl/hzd_match.sv
// Compares one producer destination against every used consumer source.
module hzd_match #(
    parameter int REG_W = 5,
    parameter int NSRC  = 2
) (
    input  logic [NSRC-1:0][REG_W-1:0] src,
    input  logic [NSRC-1:0]            src_used,
    input  logic [REG_W-1:0]           dst,
    input  logic                       dst_valid,
    output logic                       hit
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic [NSRC-1:0] per_src;

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_src
            assign per_src[g] = dst_valid && (dst != ZERO_REG) &&
                                src_used[g] && (src[g] == dst);
        end
    endgenerate

    assign hit = |per_src;
endmodule

// File: rtl/hzd_seq.sv
// Hold sequencer: tracks consecutive stall cycles and drives the outputs.
module hzd_seq
    import hzd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stall_req,
    input  logic flush_req,
    input  logic is_branch,
    output logic pc_write,
    output logic ifid_write,
    output logic control_zero,
    output logic ifid_flush
);
    hold_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = ST_RUN;
        unique case (state_q)
            ST_RUN:      state_d = stall_req ? ST_HOLD_ONE : ST_RUN;
            ST_HOLD_ONE: state_d = stall_req ? ST_HOLD_TWO : ST_RUN;
            ST_HOLD_TWO: state_d = stall_req ? ST_HOLD_TWO : ST_RUN;
            default:     state_d = ST_RUN;
        endcase
    end

    always_comb begin
        if (!rst_n) begin
            pc_write     = 1'b1;
            ifid_write   = 1'b1;
            control_zero = 1'b0;
            ifid_flush   = 1'b0;
        end else begin
            pc_write     = !stall_req;
            ifid_write   = !stall_req;
            control_zero = stall_req;
            ifid_flush   = flush_req && !stall_req;
        end
    end

    // R5: a third consecutive stall cycle never occurs
    a_r5_max_two_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD_TWO) |-> !stall_req)
        else $error("R5: stall held beyond two cycles");

    // R2: a second consecutive stall cycle only serves a decode-stage branch
    a_r2_second_hold_branch_only: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD_ONE && stall_req) |-> is_branch)
        else $error("R2: second stall cycle for a non-branch consumer");
endmodule

// File: rtl/hazard_stall_unit.sv
module hazard_stall_unit #(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] id_rs,
    input  logic [REG_W-1:0] id_rt,
    input  logic             id_uses_rs,
    input  logic             id_uses_rt,
    input  logic             id_is_branch,
    input  logic             id_branch_taken,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_reg_write,
    input  logic             ex_mem_read,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_reg_write,
    input  logic             mem_mem_read,
    output logic             pc_write,
    output logic             ifid_write,
    output logic             control_zero,
    output logic             ifid_flush
);
    localparam int NSRC = 2;

    logic [NSRC-1:0][REG_W-1:0] srcs;
    logic [NSRC-1:0]            used;
    logic ex_hit, mem_hit;
    logic load_use, branch_on_alu, branch_on_old_load;
    logic stall_req, flush_req;

    assign srcs = {id_rt, id_rs};
    assign used = {id_uses_rt, id_uses_rs};

    hzd_match #(.REG_W(REG_W), .NSRC(NSRC)) u_ex_match (
        .src(srcs), .src_used(used), .dst(ex_rd),
        .dst_valid(ex_reg_write || ex_mem_read), .hit(ex_hit)
    );

    hzd_match #(.REG_W(REG_W), .NSRC(NSRC)) u_mem_match (
        .src(srcs), .src_used(used), .dst(mem_rd),
        .dst_valid(mem_mem_read), .hit(mem_hit)
    );

    // load in execute: any consumer waits
    assign load_use           = ex_mem_read && ex_hit;
    // ALU result in execute: only a decode-stage compare must wait
    assign branch_on_alu      = id_is_branch && ex_reg_write && !ex_mem_read && ex_hit;
    // load in memory: its data is not yet available to a decode compare
    assign branch_on_old_load = id_is_branch && mem_reg_write && mem_hit;

    assign stall_req = load_use || branch_on_alu || branch_on_old_load;
    assign flush_req = id_is_branch && id_branch_taken;

    hzd_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .stall_req(stall_req), .flush_req(flush_req), .is_branch(id_is_branch),
        .pc_write(pc_write), .ifid_write(ifid_write),
        .control_zero(control_zero), .ifid_flush(ifid_flush)
    );

    // R1: a load in execute feeding a used source freezes the front end
    a_r1_load_use_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_mem_read && ex_rd != '0 &&
         ((id_uses_rs && id_rs == ex_rd) || (id_uses_rt && id_rt == ex_rd)))
        |-> (control_zero && !pc_write && !ifid_write))
        else $error("R1: load-use not stalled");

    // R7: register zero producers never stall
    a_r7_zero_dst: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rd == '0 && mem_rd == '0) |-> !control_zero)
        else $error("R7: stall on register zero");

    // R10: flush suppressed under stall
    a_r10_stall_over_flush: assert property (@(posedge clk) disable iff (!rst_n)
        control_zero |-> !ifid_flush)
        else $error("R10: flush during stall");

    // R9: taken branch that proceeds flushes the fetched instruction
    a_r9_taken_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (id_is_branch && id_branch_taken && pc_write) |-> ifid_flush)
        else $error("R9: taken branch without flush");

    // R1: PC and fetch/decode register are frozen together
    a_r1_hold_together: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_write == ifid_write) && (control_zero == !pc_write))
        else $error("R1: inconsistent hold outputs");
endmodule

// File: tb/hazard_stall_unit_bench.sv
module hazard_stall_unit_bench;
    localparam int REG_W = 5;

    typedef enum int {K_NOP, K_ALU, K_LOAD, K_BR} kind_e;
    typedef struct {
        kind_e    kind;
        int       dst;
        int       rs;
        int       rt;
        bit       use_rs;
        bit       use_rt;
        bit       taken;
    } instr_t;

    logic clk = 0;
    logic rst_n = 0;
    logic [REG_W-1:0] id_rs = 0, id_rt = 0, ex_rd = 0, mem_rd = 0;
    logic id_uses_rs = 0, id_uses_rt = 0, id_is_branch = 0, id_branch_taken = 0;
    logic ex_reg_write = 0, ex_mem_read = 0, mem_reg_write = 0, mem_mem_read = 0;
    logic pc_write, ifid_write, control_zero, ifid_flush;

    always #10 clk = ~clk;

    hazard_stall_unit #(.REG_W(REG_W)) u_hazard_stall_unit (
        .clk(clk), .rst_n(rst_n),
        .id_rs(id_rs), .id_rt(id_rt), .id_uses_rs(id_uses_rs), .id_uses_rt(id_uses_rt),
        .id_is_branch(id_is_branch), .id_branch_taken(id_branch_taken),
        .ex_rd(ex_rd), .ex_reg_write(ex_reg_write), .ex_mem_read(ex_mem_read),
        .mem_rd(mem_rd), .mem_reg_write(mem_reg_write), .mem_mem_read(mem_mem_read),
        .pc_write(pc_write), .ifid_write(ifid_write),
        .control_zero(control_zero), .ifid_flush(ifid_flush)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    // scoreboard queues: expected and observed {stalls, flushes} per sequence
    int    exp_q[$];
    int    got_q[$];
    string tag_q[$];

    instr_t prog[$];
    instr_t dec_s, ex_s, mem_s;

    function automatic instr_t nop();
        instr_t n;
        n.kind = K_NOP; n.dst = 0; n.rs = 0; n.rt = 0;
        n.use_rs = 0; n.use_rt = 0; n.taken = 0;
        return n;
    endfunction

    function automatic instr_t mk(kind_e k, int d, int s, int t, bit us, bit ut, bit tk);
        instr_t n;
        n.kind = k; n.dst = d; n.rs = s; n.rt = t;
        n.use_rs = us; n.use_rt = ut; n.taken = tk;
        return n;
    endfunction

    task automatic check(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic drive_slots();
        id_rs           = dec_s.rs[REG_W-1:0];
        id_rt           = dec_s.rt[REG_W-1:0];
        id_uses_rs      = dec_s.use_rs;
        id_uses_rt      = dec_s.use_rt;
        id_is_branch    = (dec_s.kind == K_BR);
        id_branch_taken = dec_s.taken;
        ex_rd           = ex_s.dst[REG_W-1:0];
        ex_reg_write    = (ex_s.kind == K_ALU) || (ex_s.kind == K_LOAD);
        ex_mem_read     = (ex_s.kind == K_LOAD);
        mem_rd          = mem_s.dst[REG_W-1:0];
        mem_reg_write   = (mem_s.kind == K_ALU) || (mem_s.kind == K_LOAD);
        mem_mem_read    = (mem_s.kind == K_LOAD);
    endtask

    // driver: pushes expectations, runs the occupancy model, records results
    task automatic run_seq(string tag, int exp_stalls, int exp_flush);
        int pc = 0;
        int st = 0;
        int fl = 0;
        exp_q.push_back(exp_stalls);
        exp_q.push_back(exp_flush);
        tag_q.push_back(tag);
        dec_s = nop(); ex_s = nop(); mem_s = nop();
        drive_slots();
        for (int c = 0; c < prog.size() + 8; c++) begin
            bit s, f;
            @(negedge clk);
            s = control_zero;
            f = ifid_flush;
            if (s) st++;
            if (f) fl++;
            mem_s = ex_s;
            ex_s  = s ? nop() : dec_s;
            if (!s) begin
                if (pc < prog.size()) begin
                    dec_s = f ? nop() : prog[pc];
                    pc++;
                end else begin
                    dec_s = nop();
                end
            end
            drive_slots();
        end
        got_q.push_back(st);
        got_q.push_back(fl);
        prog.delete();
    endtask

    // monitor: compares observed counts against expectations
    initial begin
        forever begin
            @(negedge clk);
            while (got_q.size() >= 2 && exp_q.size() >= 2) begin
                string t;
                int gs, gf, es, ef;
                t  = tag_q.pop_front();
                gs = got_q.pop_front(); gf = got_q.pop_front();
                es = exp_q.pop_front(); ef = exp_q.pop_front();
                check({t, " stall cycles"}, gs, es);
                check({t, " flush cycles"}, gf, ef);
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                checks++;
                fails++;
                $display("FAIL watchdog: got timeout expected completion");
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        // R11: outputs idle during reset even with a hazard presented
        id_rs = 5; id_uses_rs = 1; ex_rd = 5; ex_mem_read = 1; ex_reg_write = 1;
        id_is_branch = 1; id_branch_taken = 1;
        repeat (3) @(negedge clk);
        check("R11 reset pc_write", pc_write, 1);
        check("R11 reset control_zero", control_zero, 0);
        check("R11 reset ifid_flush", ifid_flush, 0);
        rst_n = 1;
        @(negedge clk);
        // R1, R10: same stimulus out of reset stalls and suppresses flush
        check("R1 stall pc_write", pc_write, 0);
        check("R1 stall ifid_write", ifid_write, 0);
        check("R1 stall control_zero", control_zero, 1);
        check("R10 flush suppressed", ifid_flush, 0);
        // R8: same registers but source unused
        id_uses_rs = 0; id_is_branch = 0; id_branch_taken = 0;
        @(negedge clk);
        check("R8 unused source", control_zero, 0);
        ex_mem_read = 0; ex_reg_write = 0; ex_rd = 0;
        @(negedge clk);

        // R2: load then ALU consumer
        prog.push_back(mk(K_LOAD, 5, 1, 0, 1, 0, 0));
        prog.push_back(mk(K_ALU, 8, 5, 2, 1, 1, 0));
        run_seq("R2 load->alu", 1, 0);
        // R3: ALU then branch
        prog.push_back(mk(K_ALU, 3, 1, 2, 1, 1, 0));
        prog.push_back(mk(K_BR, 0, 3, 4, 1, 1, 0));
        run_seq("R3 alu->branch", 1, 0);
        // R4: load, other, branch
        prog.push_back(mk(K_LOAD, 4, 1, 0, 1, 0, 0));
        prog.push_back(mk(K_ALU, 9, 1, 2, 1, 1, 0));
        prog.push_back(mk(K_BR, 0, 4, 0, 1, 1, 0));
        run_seq("R4 load-2->branch", 1, 0);
        // R5: load then branch
        prog.push_back(mk(K_LOAD, 6, 1, 0, 1, 0, 0));
        prog.push_back(mk(K_BR, 0, 6, 0, 1, 1, 0));
        run_seq("R5 load->branch", 2, 0);
        // R6: ALU producer two earlier for a branch
        prog.push_back(mk(K_ALU, 7, 1, 2, 1, 1, 0));
        prog.push_back(mk(K_ALU, 10, 1, 2, 1, 1, 0));
        prog.push_back(mk(K_BR, 0, 7, 0, 1, 1, 0));
        run_seq("R6 alu-2->branch", 0, 0);
        // R6: ALU producer three earlier for a branch
        prog.push_back(mk(K_ALU, 7, 1, 2, 1, 1, 0));
        prog.push_back(mk(K_ALU, 10, 1, 2, 1, 1, 0));
        prog.push_back(mk(K_ALU, 11, 1, 2, 1, 1, 0));
        prog.push_back(mk(K_BR, 0, 0, 7, 1, 1, 0));
        run_seq("R6 alu-3->branch", 0, 0);
        // R6: ALU to ALU
        prog.push_back(mk(K_ALU, 2, 1, 3, 1, 1, 0));
        prog.push_back(mk(K_ALU, 12, 2, 2, 1, 1, 0));
        run_seq("R6 alu->alu", 0, 0);
        // R7: load to register zero
        prog.push_back(mk(K_LOAD, 0, 1, 0, 1, 0, 0));
        prog.push_back(mk(K_BR, 0, 0, 0, 1, 1, 0));
        run_seq("R7 zero dst", 0, 0);
        // R8: load, consumer with the matching register flagged unused
        prog.push_back(mk(K_LOAD, 5, 1, 0, 1, 0, 0));
        prog.push_back(mk(K_ALU, 8, 5, 2, 0, 1, 0));
        run_seq("R8 unused src", 0, 0);
        // R9: taken and not-taken branches with no hazard
        prog.push_back(mk(K_BR, 0, 1, 2, 1, 1, 1));
        run_seq("R9 taken", 0, 1);
        prog.push_back(mk(K_BR, 0, 1, 2, 1, 1, 0));
        run_seq("R9 not taken", 0, 0);
        // R10: taken branch behind a load: flush only after both stalls
        prog.push_back(mk(K_LOAD, 6, 1, 0, 1, 0, 0));
        prog.push_back(mk(K_BR, 0, 6, 0, 1, 1, 1));
        run_seq("R10 stall then flush", 2, 1);

        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule